// File: doc/BRIEF.md
# Nonvolatile memory write controller

This block is the control and status register of an on-chip nonvolatile store, together with the sequencer that times its erase and write cycles. Software reaches the register through a simple single-cycle write strobe and a continuously readable value. The register selects the target space (data, program or configuration), starts one-clock reads and starts self-timed erase or write cycles. A behavioural array with a fixed, parameterised program time stands in for the storage cells. One array serves every space. The space selects only decide whether a read is allowed.

Both start bits can only be set by software and are cleared by hardware. A write start needs the write-enable bit, which must already be set in the register before the access that sets the start bit. A write start without it is an improper attempt and raises the error flag. A warm reset that arrives during a cycle discards the array update and raises the error flag. It keeps the space selects so that software can see what was being done. A power-on reset clears the whole register.

Register value, bit 7 down to bit 0: program-space select, configuration select, always 0, erase mode, error flag, write enable, write start, read start.

Top module: `nvm_ctl`

## Requirements
- R1: After power-on reset the register reads 0x00 and busy is 0.
- R2: Writing 1 to bit 0 while bits 7 and 6 are 0 and no cycle runs makes bit 0 read 1 for exactly one clock. Bit 0 then returns to 0, and at that same edge rdata takes the word at addr.
- R3: A read start is ignored, leaving bit 0 at 0 and rdata unchanged, while bit 7 or bit 6 is 1 or while a cycle is in progress.
- R4: Writing 1 to bit 1 while bit 2 is already 1 starts a cycle. Busy and bit 1 stay high for exactly PROG_CYCLES clocks, then both fall and the array holds wdata at addr.
- R5: Software writing 0 to bit 1 during a cycle does not clear it.
- R6: Writing 1 to bit 1 while bit 2 is 0 sets bit 3, starts no cycle and leaves the array unchanged.
- R7: With bit 4 at 1, a write start erases every word of the aligned row of 2**ROW_W words containing addr to all ones. Bit 4 reads 0 once the erase is done.
- R8: A cycle that completes normally leaves bit 3 at 0, even if it was 1 when the cycle started.
- R9: A warm reset during a cycle sets bit 3 and clears bits 1, 2 and 4 and busy. It keeps bits 7 and 6 and leaves the addressed word unchanged.
- R10: A warm reset outside a cycle keeps bits 7, 6 and 3 and clears bits 4, 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| wrst_n | input | 1 | Warm reset, synchronous, active low |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Value written to the register |
| reg_rdata | output | 8 | Current register value |
| addr | input | ADDR_W | Word address for reads, writes and erases |
| wdata | input | DATA_W | Word to program |
| rdata | output | DATA_W | Last word read |
| busy | output | 1 | High during a self-timed cycle |

## Verification
The hardest case to reach is a warm reset that falls inside a self-timed cycle. The bench starts a write with the program-space select set. It waits a few clocks so that busy is high and the count is partway through, then pulses the warm reset. It reads the register to see the error flag and the kept select. It then clears the select and reads back the targeted word, which must still hold its old value. A second warm reset with no cycle running shows that the error flag and the selects survive it.

// File: rtl/nvm_ctl.sv
module nvm_ctl #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int ROW_W       = 2,
  parameter int PROG_CYCLES = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wrst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int ROW_WORDS = 1 << ROW_W;
  localparam int CW        = $clog2(PROG_CYCLES) + 1;

  logic              sel_prog, sel_cfg, erase, err, wen, wr, rd;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic [DATA_W-1:0] mem [DEPTH];

  wire done     = wr && cnt == '0;
  wire commit   = done && por_n && wrst_n;
  wire go_write = reg_we && reg_wdata[1] && !wr && wen;
  wire bad_wr   = reg_we && reg_wdata[1] && !wr && !wen;
  wire go_read  = reg_we && reg_wdata[0] && !wr && !rd && !sel_prog && !sel_cfg;

  assign reg_rdata = {sel_prog, sel_cfg, 1'b0, erase, err, wen, wr, rd};
  assign busy      = wr;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      {sel_prog, sel_cfg, erase, err, wen, wr, rd} <= '0;
      cnt   <= '0;
      rdata <= '0;
    end else if (!wrst_n) begin
      if (wr) err <= 1'b1;
      erase <= 1'b0;
      wen   <= 1'b0;
      wr    <= 1'b0;
      rd    <= 1'b0;
      cnt   <= '0;
    end else begin
      if (rd) begin
        rdata <= mem[addr];
        rd    <= 1'b0;
      end
      if (reg_we) begin
        wen <= reg_wdata[2];
        err <= reg_wdata[3];
        if (!wr) begin
          sel_prog <= reg_wdata[7];
          sel_cfg  <= reg_wdata[6];
          erase    <= reg_wdata[4];
        end
      end
      if (go_read) rd <= 1'b1;
      if (bad_wr) err <= 1'b1;
      if (go_write) begin
        wr       <= 1'b1;
        cnt      <= CW'(PROG_CYCLES - 1);
        lat_addr <= addr;
        lat_data <= wdata;
      end
      if (wr && !done) cnt <= cnt - 1'b1;
      if (done) begin
        wr    <= 1'b0;
        err   <= 1'b0;
        erase <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      if (erase) begin
        for (int i = 0; i < ROW_WORDS; i++)
          mem[{lat_addr[ADDR_W-1:ROW_W], ROW_W'(i)}] <= '1;
      end else begin
        mem[lat_addr] <= lat_data;
      end
    end
  end

  // R4
  start_needs_wen_chk: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    $rose(wr) |-> $past(wen));

  // R2
  read_one_clock_chk: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    rd |=> !rd);

  // R3
  read_refused_chk: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    $rose(rd) |-> (!$past(sel_prog) && !$past(sel_cfg) && !$past(wr)));

  // R7
  erase_self_clear_chk: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    (done && erase) |=> !erase);

  // R8
  done_clears_err_chk: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    done |=> (!err && !wr));

  // R9
  warm_abort_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!wrst_n && wr) |=> (err && !wr && !busy));

  // R6
  improper_flag_chk: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    bad_wr |=> (err && !wr));
endmodule

// File: tb/nvm_ctl_test.sv
module nvm_ctl_test;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int PC = 8;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          wrst_n = 1'b1;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          busy;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [DW-1:0] expq [$];
  string         tagq [$];
  bit            rd_was = 0;

  nvm_ctl #(.ADDR_W(AW), .DATA_W(DW), .ROW_W(2), .PROG_CYCLES(PC)) uut (
    .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy));

  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: a read start that just ended yields a word to compare
  always @(negedge clk) begin
    if (rd_was && !reg_rdata[0]) begin
      if (expq.size() == 0) check("R2 unexpected read", 32'(rdata), 32'hdead);
      else check(tagq.pop_front(), 32'(rdata), 32'(expq.pop_front()));
    end
    rd_was = reg_rdata[0];
  end

  task automatic wreg(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_word(string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    addr = a;
    expq.push_back(exp);
    tagq.push_back(req);
    wreg(8'h01);
    check({req, " bit0 set"}, 32'(reg_rdata[0]), 1);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [7:0] ctl, output int n);
    addr = a; wdata = d;
    wreg(ctl);
    wreg(ctl | 8'h02);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check("R1 reset reg", 32'(reg_rdata), 32'h00);
    check("R1 reset busy", 32'(busy), 0);

    do_write(6'd5, 8'h3C, 8'h04, n);
    check("R4 busy length", n, PC);
    check("R4 wr cleared", 32'(reg_rdata[1]), 0);
    rd_word("R2 read word", 6'd5, 8'h3C);
    do_write(6'd3, 8'hA5, 8'h04, n);
    rd_word("R2 read second", 6'd3, 8'hA5);

    wreg(8'h80); addr = 6'd5; wreg(8'h81);
    check("R3 refused prog", 32'(reg_rdata[0]), 0);
    @(negedge clk);
    check("R3 rdata kept", 32'(rdata), 32'hA5);
    wreg(8'h40); wreg(8'h41);
    check("R3 refused cfg", 32'(reg_rdata[0]), 0);

    wreg(8'h04); addr = 6'd7; wdata = 8'h11;
    wreg(8'h06);
    wreg(8'h05);
    check("R5 wr kept", 32'(reg_rdata[1]), 1);
    check("R3 refused busy", 32'(reg_rdata[0]), 0);
    while (busy) @(negedge clk);

    wreg(8'h00); addr = 6'd5; wdata = 8'h77;
    wreg(8'h02);
    check("R6 err set", 32'(reg_rdata), 32'h08);
    check("R6 no busy", 32'(busy), 0);
    rd_word("R6 array unchanged", 6'd5, 8'h3C);

    do_write(6'd8, 8'h01, 8'h04, n);
    do_write(6'd10, 8'h02, 8'h04, n);
    do_write(6'd12, 8'h03, 8'h04, n);
    do_write(6'd9, 8'h00, 8'h14, n);
    check("R7 erase done", 32'(reg_rdata[4]), 0);
    rd_word("R7 erased 8", 6'd8, 8'hFF);
    rd_word("R7 erased 10", 6'd10, 8'hFF);
    rd_word("R7 erased 11", 6'd11, 8'hFF);
    rd_word("R7 next row kept", 6'd12, 8'h03);

    wreg(8'h0C); addr = 6'd20; wdata = 8'h5A;
    wreg(8'h0E);
    check("R8 err held during", 32'(reg_rdata[3]), 1);
    while (busy) @(negedge clk);
    check("R8 err cleared", 32'(reg_rdata[3]), 0);

    addr = 6'd3; wdata = 8'hEE;
    wreg(8'h84); wreg(8'h86);
    @(negedge clk); @(negedge clk);
    wrst_n = 1'b0; @(negedge clk); wrst_n = 1'b1;
    check("R9 warm abort reg", 32'(reg_rdata), 32'h88);
    check("R9 busy low", 32'(busy), 0);
    repeat (PC) @(negedge clk);
    wreg(8'h00);
    rd_word("R9 word unchanged", 6'd3, 8'hA5);

    wreg(8'h5C);
    wrst_n = 1'b0; @(negedge clk); wrst_n = 1'b1;
    check("R10 warm idle reg", 32'(reg_rdata), 32'h48);

    check("R2 queue drained", expq.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule